// File: doc/BRIEF.md
# Encrypting Serial Bus Bridge

This block sits between a processor's memory-mapped slave port and a narrow byte-wide serial link to a downstream controller. Each read or write the processor issues becomes a short serial frame: a command byte, the word address and, for a write, the data word. The bridge then waits for the far side to answer. A read answer is four data bytes, which the bridge reassembles into a word. A write answer is one acknowledge byte. Waitrequest stays high for the whole exchange, so the processor is stalled until the transfer has finished.

A separate configuration port holds two 64-bit keys and a crypto-enable bit. The keys are a pass key and a card key, and each is written as two 32-bit halves. When crypto is enabled, outgoing write data is enciphered before it is serialized and incoming read data is deciphered after it is reassembled. The processor therefore only ever handles plaintext, while the far side only ever stores ciphertext. This applies to both instruction fetches and data accesses. The cipher has four rounds, and each round uses one nibble of each key. Round r (r = 0..3) uses the nibble at bits [47:44], [43:40], [7:4] and [3:0] of each key, in that order. A round XORs every nibble of the word with the pass-key nibble, then rotates the word left by the card-key nibble's value in bits. Deciphering runs the inverse steps in reverse round order.

Top module: `sc_bridge`

## Requirements
- R1: After a synchronous reset (active-high `rst`), every key half and the enable bit read back as zero, `s_waitreq` is high and `tx_valid` is low.
- R2: An accepted request produces a frame on consecutive `tx_valid` cycles. The first byte is the command byte: bits [7:1] are zero and bit 0 is 1 for a write. Three address bytes follow, most significant first, holding `s_addr` (already a word address). A write adds four data bytes, most significant first, so a write frame is 8 bytes and a read frame is 4.
- R3: `s_waitreq` stays high from acceptance until the final response byte has been clocked in on `rx_valid`. That final byte is the fourth data byte for a read and the single acknowledge byte for a write. `s_waitreq` is low in the next cycle only, then returns high.
- R4: For a read, the four response bytes are assembled most significant first, and the resulting word is on `s_rdata` while `s_waitreq` is low.
- R5: Configuration offsets are 0 for the pass key bits [31:0], 1 for the pass key bits [63:32], 2 for the card key bits [31:0], 3 for the card key bits [63:32], and 4 for the enable bit. Each can be read back on `c_rdata`. Offsets 5 to 7 read as zero and ignore writes.
- R6: Only bit 0 of a write to offset 4 is stored, and bits [31:1] of its readback are zero. With the bit at zero, including after zero has been written over a one, data crosses the bridge unchanged in both directions.
- R7: With the enable bit at one, the data bytes of a write frame carry the encipherment of `s_wdata` described above.
- R8: With the enable bit at one, `s_rdata` is the decipherment of the returned word, so reading back a word that was written enciphered returns the original plaintext.
- R9: Only one transfer is outstanding at a time. No frame byte is sent while `s_waitreq` is low, and a new request is taken only after the release cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| s_addr | input | 24 | Word address of the processor request |
| s_read | input | 1 | Read request, held until waitrequest drops |
| s_write | input | 1 | Write request, held until waitrequest drops (wins over read) |
| s_wdata | input | 32 | Write data from the processor |
| s_rdata | output | 32 | Read data returned to the processor |
| s_waitreq | output | 1 | Stall; low for one cycle when a transfer completes |
| c_addr | input | 3 | Configuration register offset |
| c_write | input | 1 | Configuration write strobe |
| c_wdata | input | 32 | Configuration write data |
| c_rdata | output | 32 | Configuration readback of the offset on c_addr |
| tx_data | output | 8 | Outgoing frame byte |
| tx_valid | output | 1 | Outgoing byte valid |
| rx_data | input | 8 | Response byte from the far side |
| rx_valid | input | 1 | Response byte valid |

## Verification
The assertions assume two things about the inputs. First, the processor holds its request and its address and data steady until it sees `s_waitreq` low. Second, the far side sends `rx_valid` only after a complete frame and sends exactly the number of response bytes that frame type calls for. The bench keeps to both: it raises a request at a falling edge and holds it until the release cycle. It answers only after it has counted the whole frame on `tx_valid`, and it sends one byte per cycle, the right number for the frame type. Configuration writes are made between transfers, never while a frame is in flight.

// File: rtl/sc_pkg.sv
package sc_pkg;

    localparam int WORD_W  = 32;
    localparam int KEY_W   = 64;
    localparam int NIB_W   = 4;
    localparam int ROUNDS  = 4;
    localparam int NIB_CNT = WORD_W / NIB_W;

    typedef enum logic [1:0] {
        LS_IDLE,
        LS_SEND,
        LS_WAIT,
        LS_DONE
    } link_state_e;

    typedef struct packed {
        logic [KEY_W-1:0] pass_key;
        logic [KEY_W-1:0] card_key;
        logic             crypt_en;
    } key_set_t;

    // Nibble of a key used by round r; the order matters to the cipher.
    function automatic logic [NIB_W-1:0] key_nib(input logic [KEY_W-1:0] k,
                                                 input logic [1:0] r);
        case (r)
            2'd0:    return k[47:44];
            2'd1:    return k[43:40];
            2'd2:    return k[7:4];
            default: return k[3:0];
        endcase
    endfunction

    function automatic logic [WORD_W-1:0] rotl(input logic [WORD_W-1:0] w,
                                               input logic [NIB_W-1:0] a);
        return (w << a) | (w >> (WORD_W - int'(a)));
    endfunction

    function automatic logic [WORD_W-1:0] rotr(input logic [WORD_W-1:0] w,
                                               input logic [NIB_W-1:0] a);
        return (w >> a) | (w << (WORD_W - int'(a)));
    endfunction

    function automatic logic [WORD_W-1:0] encipher(input logic [WORD_W-1:0] din,
                                                   input logic [KEY_W-1:0] pk,
                                                   input logic [KEY_W-1:0] ck);
        logic [WORD_W-1:0] w;
        w = din;
        for (int r = 0; r < ROUNDS; r++) begin
            w = w ^ {NIB_CNT{key_nib(pk, 2'(r))}};
            w = rotl(w, key_nib(ck, 2'(r)));
        end
        return w;
    endfunction

    function automatic logic [WORD_W-1:0] decipher(input logic [WORD_W-1:0] din,
                                                   input logic [KEY_W-1:0] pk,
                                                   input logic [KEY_W-1:0] ck);
        logic [WORD_W-1:0] w;
        w = din;
        for (int r = ROUNDS - 1; r >= 0; r--) begin
            w = rotr(w, key_nib(ck, 2'(r)));
            w = w ^ {NIB_CNT{key_nib(pk, 2'(r))}};
        end
        return w;
    endfunction

endpackage

// File: rtl/sc_cfg_regs.sv
module sc_cfg_regs
    import sc_pkg::*;
#(
    parameter int CFG_AW = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CFG_AW-1:0] c_addr,
    input  logic              c_write,
    input  logic [WORD_W-1:0] c_wdata,
    output logic [WORD_W-1:0] c_rdata,
    output key_set_t          keys
);

    localparam logic [CFG_AW-1:0] OFS_PASS_LO = CFG_AW'(0);
    localparam logic [CFG_AW-1:0] OFS_PASS_HI = CFG_AW'(1);
    localparam logic [CFG_AW-1:0] OFS_CARD_LO = CFG_AW'(2);
    localparam logic [CFG_AW-1:0] OFS_CARD_HI = CFG_AW'(3);
    localparam logic [CFG_AW-1:0] OFS_ENABLE  = CFG_AW'(4);

    key_set_t keys_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            keys_q <= '0;
        end else if (c_write) begin
            case (c_addr)
                OFS_PASS_LO: keys_q.pass_key[WORD_W-1:0]       <= c_wdata;
                OFS_PASS_HI: keys_q.pass_key[KEY_W-1:WORD_W]   <= c_wdata;
                OFS_CARD_LO: keys_q.card_key[WORD_W-1:0]       <= c_wdata;
                OFS_CARD_HI: keys_q.card_key[KEY_W-1:WORD_W]   <= c_wdata;
                OFS_ENABLE:  keys_q.crypt_en                   <= c_wdata[0];
                default: ;
            endcase
        end
    end

    always_comb begin
        case (c_addr)
            OFS_PASS_LO: c_rdata = keys_q.pass_key[WORD_W-1:0];
            OFS_PASS_HI: c_rdata = keys_q.pass_key[KEY_W-1:WORD_W];
            OFS_CARD_LO: c_rdata = keys_q.card_key[WORD_W-1:0];
            OFS_CARD_HI: c_rdata = keys_q.card_key[KEY_W-1:WORD_W];
            OFS_ENABLE:  c_rdata = {{(WORD_W-1){1'b0}}, keys_q.crypt_en};
            default:     c_rdata = '0;
        endcase
    end

    assign keys = keys_q;

endmodule

// File: rtl/sc_nibble_cipher.sv
module sc_nibble_cipher
    import sc_pkg::*;
#(
    parameter bit INVERSE = 1'b0
) (
    input  key_set_t          keys,
    input  logic [WORD_W-1:0] din,
    output logic [WORD_W-1:0] dout
);

    generate
        if (INVERSE) begin : g_dec
            assign dout = decipher(din, keys.pass_key, keys.card_key);
        end else begin : g_enc
            assign dout = encipher(din, keys.pass_key, keys.card_key);
        end
    endgenerate

endmodule

// File: rtl/sc_link_ctrl.sv
module sc_link_ctrl
    import sc_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int LINK_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] s_addr,
    input  logic              s_read,
    input  logic              s_write,
    input  logic [WORD_W-1:0] tx_word,
    input  logic              crypt_in,
    output logic              crypt_q,
    output logic [WORD_W-1:0] rx_word,
    output logic              s_waitreq,
    output logic [LINK_W-1:0] tx_data,
    output logic              tx_valid,
    input  logic [LINK_W-1:0] rx_data,
    input  logic              rx_valid
);

    localparam int ADDR_BYTES = ADDR_W / LINK_W;
    localparam int DATA_BYTES = WORD_W / LINK_W;
    localparam int FRAME_MAX  = 1 + ADDR_BYTES + DATA_BYTES;
    localparam int FRAME_RD   = 1 + ADDR_BYTES;
    localparam int FRAME_W    = FRAME_MAX * LINK_W;
    localparam int CNT_W      = $clog2(FRAME_MAX + 1);

    link_state_e        state_q;
    logic [FRAME_W-1:0] frame_q;
    logic [CNT_W-1:0]   cnt_q;
    logic               is_wr_q;
    logic [WORD_W-1:0]  rx_q;
    logic               crypt_r;
    logic               last_cnt;

    assign last_cnt = (cnt_q == CNT_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= LS_IDLE;
            frame_q <= '0;
            cnt_q   <= '0;
            is_wr_q <= 1'b0;
            rx_q    <= '0;
            crypt_r <= 1'b0;
        end else begin
            case (state_q)
                LS_IDLE: begin
                    if (s_read || s_write) begin
                        frame_q <= {{(LINK_W-1){1'b0}}, s_write, s_addr,
                                    s_write ? tx_word : {WORD_W{1'b0}}};
                        cnt_q   <= s_write ? CNT_W'(FRAME_MAX) : CNT_W'(FRAME_RD);
                        is_wr_q <= s_write;
                        crypt_r <= crypt_in;
                        state_q <= LS_SEND;
                    end
                end
                LS_SEND: begin
                    frame_q <= frame_q << LINK_W;
                    if (last_cnt) begin
                        cnt_q   <= is_wr_q ? CNT_W'(1) : CNT_W'(DATA_BYTES);
                        state_q <= LS_WAIT;
                    end else begin
                        cnt_q <= cnt_q - CNT_W'(1);
                    end
                end
                LS_WAIT: begin
                    if (rx_valid) begin
                        if (!is_wr_q) begin
                            rx_q <= {rx_q[WORD_W-LINK_W-1:0], rx_data};
                        end
                        cnt_q <= cnt_q - CNT_W'(1);
                        if (last_cnt) begin
                            state_q <= LS_DONE;
                        end
                    end
                end
                default: begin
                    state_q <= LS_IDLE;
                end
            endcase
        end
    end

    assign tx_valid  = (state_q == LS_SEND);
    assign tx_data   = frame_q[FRAME_W-1 -: LINK_W];
    assign s_waitreq = (state_q != LS_DONE);
    assign rx_word   = rx_q;
    assign crypt_q   = crypt_r;

endmodule

// File: rtl/sc_bridge.sv
module sc_bridge
    import sc_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int LINK_W = 8,
    parameter int CFG_AW = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] s_addr,
    input  logic              s_read,
    input  logic              s_write,
    input  logic [WORD_W-1:0] s_wdata,
    output logic [WORD_W-1:0] s_rdata,
    output logic              s_waitreq,
    input  logic [CFG_AW-1:0] c_addr,
    input  logic              c_write,
    input  logic [WORD_W-1:0] c_wdata,
    output logic [WORD_W-1:0] c_rdata,
    output logic [LINK_W-1:0] tx_data,
    output logic              tx_valid,
    input  logic [LINK_W-1:0] rx_data,
    input  logic              rx_valid
);

    key_set_t          keys;
    logic [WORD_W-1:0] enc_word;
    logic [WORD_W-1:0] dec_word;
    logic [WORD_W-1:0] rx_word;
    logic              crypt_q;

    sc_cfg_regs #(.CFG_AW(CFG_AW)) i_cfg (
        .clk     (clk),
        .rst     (rst),
        .c_addr  (c_addr),
        .c_write (c_write),
        .c_wdata (c_wdata),
        .c_rdata (c_rdata),
        .keys    (keys)
    );

    sc_nibble_cipher #(.INVERSE(1'b0)) i_enc (
        .keys (keys),
        .din  (s_wdata),
        .dout (enc_word)
    );

    sc_nibble_cipher #(.INVERSE(1'b1)) i_dec (
        .keys (keys),
        .din  (rx_word),
        .dout (dec_word)
    );

    sc_link_ctrl #(.ADDR_W(ADDR_W), .LINK_W(LINK_W)) i_link (
        .clk       (clk),
        .rst       (rst),
        .s_addr    (s_addr),
        .s_read    (s_read),
        .s_write   (s_write),
        .tx_word   (keys.crypt_en ? enc_word : s_wdata),
        .crypt_in  (keys.crypt_en),
        .crypt_q   (crypt_q),
        .rx_word   (rx_word),
        .s_waitreq (s_waitreq),
        .tx_data   (tx_data),
        .tx_valid  (tx_valid),
        .rx_data   (rx_data),
        .rx_valid  (rx_valid)
    );

    assign s_rdata = crypt_q ? dec_word : rx_word;

endmodule

// File: rtl/sc_bridge_chk.sv
module sc_bridge_chk #(
    parameter int LINK_W = 8,
    parameter int CFG_AW = 3
) (
    input logic              clk,
    input logic              rst,
    input logic              s_waitreq,
    input logic              tx_valid,
    input logic [LINK_W-1:0] tx_data,
    input logic [CFG_AW-1:0] c_addr,
    input logic [31:0]       c_rdata
);

    // R1: the cycle after reset the bridge is stalled and the link is quiet
    a_r1_reset_state: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (s_waitreq && !tx_valid));

    // R3: the release lasts exactly one cycle
    a_r3_release_single: assert property (@(posedge clk) disable iff (rst)
        !s_waitreq |=> s_waitreq);

    // R9: no frame byte while the processor is being released
    a_r9_idle_link_on_release: assert property (@(posedge clk) disable iff (rst)
        !s_waitreq |-> !tx_valid);

    // R2: the opening byte of every frame has only the direction bit free
    a_r2_cmd_upper_zero: assert property (@(posedge clk) disable iff (rst)
        $rose(tx_valid) |-> (tx_data[LINK_W-1:1] == '0));

    // R6: the enable register is a single bit
    a_r6_enable_one_bit: assert property (@(posedge clk) disable iff (rst)
        (c_addr == CFG_AW'(4)) |-> (c_rdata[31:1] == '0));

endmodule

bind sc_bridge sc_bridge_chk #(.LINK_W(LINK_W), .CFG_AW(CFG_AW)) i_chk (
    .clk       (clk),
    .rst       (rst),
    .s_waitreq (s_waitreq),
    .tx_valid  (tx_valid),
    .tx_data   (tx_data),
    .c_addr    (c_addr),
    .c_rdata   (c_rdata)
);

// File: tb/test_sc_bridge.sv
`timescale 1ns/1ps
module test_sc_bridge;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [23:0] s_addr = '0;
    logic        s_read = 1'b0;
    logic        s_write = 1'b0;
    logic [31:0] s_wdata = '0;
    logic [31:0] s_rdata;
    logic        s_waitreq;
    logic [2:0]  c_addr = '0;
    logic        c_write = 1'b0;
    logic [31:0] c_wdata = '0;
    logic [31:0] c_rdata;
    logic [7:0]  tx_data;
    logic        tx_valid;
    logic [7:0]  rx_data = '0;
    logic        rx_valid = 1'b0;

    int n_checks = 0;
    int n_fail = 0;

    localparam logic [63:0] PASS_K = 64'h000F000F000F000F;
    localparam logic [63:0] CARD_K = 64'h0ABCDEF012345678;

    // {write, enable, word address, data (write) or response word (read)}
    localparam int NVEC = 6;
    localparam logic [57:0] VEC [NVEC] = '{
        {1'b1, 1'b0, 24'h200048, 32'h00000002},
        {1'b0, 1'b0, 24'h200048, 32'h00C40074},
        {1'b1, 1'b1, 24'h200263, 32'hACE0ACE0},
        {1'b0, 1'b1, 24'h200263, 32'h0DEC277C},
        {1'b1, 1'b1, 24'hABCDEF, 32'hFFFFFFFF},
        {1'b0, 1'b0, 24'h000001, 32'h80000001}
    };

    sc_bridge i_sc_bridge (
        .clk (clk), .rst (rst),
        .s_addr (s_addr), .s_read (s_read), .s_write (s_write),
        .s_wdata (s_wdata), .s_rdata (s_rdata), .s_waitreq (s_waitreq),
        .c_addr (c_addr), .c_write (c_write), .c_wdata (c_wdata), .c_rdata (c_rdata),
        .tx_data (tx_data), .tx_valid (tx_valid),
        .rx_data (rx_data), .rx_valid (rx_valid)
    );

    always #10 clk = ~clk;

    // ---- model of the cipher, written from the requirement text ----
    function automatic logic [3:0] m_nib(input logic [63:0] k, input int r);
        int lo;
        lo = (r == 0) ? 44 : (r == 1) ? 40 : (r == 2) ? 4 : 0;
        return k[lo +: 4];
    endfunction

    function automatic logic [31:0] m_rol1(input logic [31:0] w);
        return {w[30:0], w[31]};
    endfunction

    function automatic logic [31:0] m_ror1(input logic [31:0] w);
        return {w[0], w[31:1]};
    endfunction

    function automatic logic [31:0] m_enc(input logic [31:0] d);
        logic [31:0] w;
        w = d;
        for (int r = 0; r < 4; r++) begin
            for (int b = 0; b < 8; b++) w[b*4 +: 4] = w[b*4 +: 4] ^ m_nib(PASS_K, r);
            for (int s = 0; s < int'(m_nib(CARD_K, r)); s++) w = m_rol1(w);
        end
        return w;
    endfunction

    function automatic logic [31:0] m_dec(input logic [31:0] d);
        logic [31:0] w;
        w = d;
        for (int r = 3; r >= 0; r--) begin
            for (int s = 0; s < int'(m_nib(CARD_K, r)); s++) w = m_ror1(w);
            for (int b = 0; b < 8; b++) w[b*4 +: 4] = w[b*4 +: 4] ^ m_nib(PASS_K, r);
        end
        return w;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic cfg_wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        c_addr = a; c_wdata = d; c_write = 1'b1;
        @(negedge clk);
        c_write = 1'b0;
    endtask

    task automatic cfg_rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        c_addr = a;
        #1 d = c_rdata;
    endtask

    // One transfer with a far-side model; returns the data word seen on the wire.
    task automatic xfer(input bit wr, input logic [23:0] a, input logic [31:0] d,
                        input bit en, output logic [31:0] wire_word);
        logic [7:0] bytes [8];
        int got;
        int need;
        int guard;
        logic [31:0] exp_w;
        @(negedge clk);
        s_addr = a; s_wdata = wr ? d : 32'h0; s_write = wr; s_read = !wr;
        need = wr ? 8 : 4;
        got = 0; guard = 0;
        while (got < need && guard < 50) begin
            @(negedge clk);
            if (tx_valid) begin bytes[got] = tx_data; got++; end
            guard++;
        end
        check(got == need, "R2", "frame length", got, need);
        check(bytes[0] == {7'b0, wr}, "R2", "command byte", bytes[0], {7'b0, wr});
        check({bytes[1], bytes[2], bytes[3]} == a, "R2", "address bytes",
              {8'h0, bytes[1], bytes[2], bytes[3]}, {8'h0, a});
        wire_word = {bytes[4], bytes[5], bytes[6], bytes[7]};
        if (wr) begin
            exp_w = en ? m_enc(d) : d;
            check(wire_word == exp_w, en ? "R7" : "R6", "write data on link", wire_word, exp_w);
        end
        @(negedge clk);
        check(!tx_valid, "R2", "link idle after frame", tx_valid, 0);
        for (int i = 0; i < (wr ? 1 : 4); i++) begin
            check(s_waitreq, "R3", "stall held before final response", s_waitreq, 1);
            rx_valid = 1'b1;
            rx_data = wr ? 8'hA5 : d[31 - 8*i -: 8];
            @(negedge clk);
        end
        rx_valid = 1'b0;
        check(!s_waitreq, "R3", "release after final response", s_waitreq, 0);
        if (!wr) begin
            exp_w = en ? m_dec(d) : d;
            check(s_rdata == exp_w, en ? "R8" : "R4", "read data", s_rdata, exp_w);
        end
        s_read = 1'b0; s_write = 1'b0;
        @(negedge clk);
        check(s_waitreq && !tx_valid, "R9", "single release, no new frame",
              {s_waitreq, tx_valid}, 2'b10);
    endtask

    initial begin
        #3_000_000;
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        logic [31:0] ct;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        check(s_waitreq && !tx_valid, "R1", "port state after reset",
              {s_waitreq, tx_valid}, 2'b10);
        for (int o = 0; o < 5; o++) begin
            cfg_rd(3'(o), rd);
            check(rd == 0, "R1", "config clear after reset", rd, 0);
        end
        // R5: key load and readback
        cfg_wr(3'd0, PASS_K[31:0]);  cfg_wr(3'd1, PASS_K[63:32]);
        cfg_wr(3'd2, CARD_K[31:0]);  cfg_wr(3'd3, CARD_K[63:32]);
        cfg_rd(3'd0, rd); check(rd == PASS_K[31:0], "R5", "pass low", rd, PASS_K[31:0]);
        cfg_rd(3'd1, rd); check(rd == PASS_K[63:32], "R5", "pass high", rd, PASS_K[63:32]);
        cfg_rd(3'd2, rd); check(rd == CARD_K[31:0], "R5", "card low", rd, CARD_K[31:0]);
        cfg_rd(3'd3, rd); check(rd == CARD_K[63:32], "R5", "card high", rd, CARD_K[63:32]);
        cfg_wr(3'd6, 32'hDEADBEEF);
        cfg_rd(3'd6, rd); check(rd == 0, "R5", "unmapped offset", rd, 0);
        // R6: only bit 0 of the enable register is stored
        cfg_wr(3'd4, 32'hFFFFFFFE);
        cfg_rd(3'd4, rd); check(rd == 0, "R6", "enable ignores upper bits", rd, 0);

        // table walk
        for (int v = 0; v < NVEC; v++) begin
            cfg_wr(3'd4, {31'h0, VEC[v][56]});
            xfer(VEC[v][57], VEC[v][55:32], VEC[v][31:0], VEC[v][56], ct);
        end

        // R8: round trip through the cipher
        cfg_wr(3'd4, 32'h1);
        xfer(1'b1, 24'h000010, 32'h13579BDF, 1'b1, ct);
        xfer(1'b0, 24'h000010, ct, 1'b1, rd);
        // R6: writing zero returns to pass-through
        cfg_wr(3'd4, 32'h0);
        cfg_rd(3'd4, rd); check(rd == 0, "R6", "enable cleared", rd, 0);
        xfer(1'b1, 24'h000020, 32'h2468ACE0, 1'b0, ct);

        // R1: reset clears loaded keys
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        cfg_rd(3'd3, rd); check(rd == 0, "R1", "card high cleared by reset", rd, 0);
        cfg_rd(3'd0, rd); check(rd == 0, "R1", "pass low cleared by reset", rd, 0);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule